// File: doc/BRIEF.md
# Memory Cycle Arbiter With Thread Scheduler

This block decides, once per clock, who owns the single shared memory cycle. Sixteen I/O controllers (eight output, eight input) and one CPU compete. The I/O side is served by a fixed-priority scan that starts again from the top on every cycle, so a controller that keeps requesting keeps winning over everything below it. The CPU only receives a cycle that no I/O controller wanted.

The CPU is time-shared by eight virtual processors. When the CPU wins a cycle at an instruction boundary, the block picks the next eligible processor in circular order after the one served last. A processor is eligible when it is switched on and not waiting on an earlier I/O transfer. Once chosen, that processor keeps every CPU cycle until its instruction reports completion. I/O cycles stolen in the middle stretch the instruction but never hand it to another processor. An instruction that finishes with the force-same flag set makes the next instruction come from the same processor.

Grant and processor ID are combinational from the current inputs and the registered scheduler state. The instruction-done and force-same flags are sampled at the clock edge of a cycle granted to the CPU.

Top module: `mem_cycle_arbiter`

## Requirements
- R1: `grant` has at most one bit set. Bits 0..7 are output controllers 0..7, bits 8..15 are input controllers 0..7, and bit 16 is the CPU.
- R2: Any output-controller request wins the cycle, and the lowest-numbered requesting output controller is granted.
- R3: With no output request, the lowest-numbered requesting input controller wins over the CPU. Priority carries no memory between cycles, so a held request from controller 0 wins on every cycle.
- R4: At an instruction boundary the CPU cycle goes to the first eligible processor after the last granted one, in circular order. After reset the search starts at processor 0.
- R5: After a CPU cycle without `instr_done`, every following CPU cycle goes to the same processor until a CPU cycle with `instr_done`.
- R6: I/O requests during an unfinished instruction take the cycle. The instruction resumes on the same processor at the next CPU cycle.
- R7: A CPU cycle with both `instr_done` and `force_same` makes the next CPU instruction come from the same processor, even if it is now disabled or stalled.
- R8: A processor whose `vp_enable` bit is 0 is never picked at a boundary. A change of `vp_enable` during an unfinished instruction does not interrupt it.
- R9: A processor whose `vp_io_wait` bit is 1 is never picked at a boundary.
- R10: With no I/O request, no instruction in progress, no forced repeat and no eligible processor, `grant` is zero. `vp_id` is zero whenever `grant[16]` is 0.
- R11: `instr_done` and `force_same` have no effect on cycles not granted to the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_req | input | 8 | Output-controller requests |
| in_req | input | 8 | Input-controller requests |
| vp_enable | input | 8 | Per-processor on/off |
| vp_io_wait | input | 8 | Per-processor stall on pending I/O |
| instr_done | input | 1 | Current CPU cycle ends the instruction |
| force_same | input | 1 | Completing instruction forces a repeat of its processor |
| grant | output | 17 | One-hot cycle grant |
| vp_id | output | 3 | Processor served when `grant[16]` is set |

## Verification
`grant` and `vp_id` answer the present inputs in the same cycle, with no register on the way. Scheduler state written at a rising edge shows up only in the results of the following cycle. The bench applies stimulus just after each falling edge and compares one time unit later, well before the next rising edge. It advances its behavioural model at the rising edge, using the same inputs, so every comparison sees exactly one state update per cycle.

// File: rtl/mem_cycle_arbiter.sv
module mem_cycle_arbiter #(
  parameter int N_OUT = 8,
  parameter int N_IN  = 8,
  parameter int N_VP  = 8,
  localparam int G    = N_OUT + N_IN + 1,
  localparam int CPU  = G - 1,
  localparam int VW   = (N_VP > 1) ? $clog2(N_VP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] out_req,
  input  logic [N_IN-1:0]  in_req,
  input  logic [N_VP-1:0]  vp_enable,
  input  logic [N_VP-1:0]  vp_io_wait,
  input  logic             instr_done,
  input  logic             force_same,
  output logic [G-1:0]     grant,
  output logic [VW-1:0]    vp_id
);

  logic          busy_q, hold_q;
  logic [VW-1:0] cur_q, pick, sel_vp;
  logic [N_VP-1:0] elig;
  logic [G-2:0]  io_req;
  logic          cpu_want;

  assign elig     = vp_enable & ~vp_io_wait;
  assign io_req   = {in_req, out_req};
  assign cpu_want = busy_q | hold_q | (|elig);

  always_comb begin
    logic found;
    int   idx;
    pick  = cur_q;
    found = 1'b0;
    for (int i = 1; i <= N_VP; i++) begin
      idx = (int'(cur_q) + i) % N_VP;
      if (!found && elig[idx]) begin
        pick  = VW'(idx);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < G - 1; i++) begin
      if (!found && io_req[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    if (!found && cpu_want) grant[CPU] = 1'b1;
  end

  assign sel_vp = (busy_q | hold_q) ? cur_q : pick;
  assign vp_id  = grant[CPU] ? sel_vp : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      cur_q  <= VW'(N_VP - 1);
    end else if (grant[CPU]) begin
      cur_q  <= sel_vp;
      busy_q <= !instr_done;
      hold_q <= instr_done & force_same;
    end
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_out_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_req) |-> (grant[CPU] == 1'b0 && (grant[G-2:N_OUT] == '0)));

  assert_in_before_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_req) |-> !grant[CPU]);

  assert_atomic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[CPU] && !instr_done) ##1 grant[CPU] |-> vp_id == $past(vp_id));

  assert_forced_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[CPU] && instr_done && force_same) ##1 grant[CPU] |-> vp_id == $past(vp_id));

  assert_pick_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[CPU] && !busy_q && !hold_q) |-> (vp_enable[vp_id] && !vp_io_wait[vp_id]));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !grant[CPU] |-> vp_id == '0);

endmodule

// File: tb/test_mem_cycle_arbiter.sv
module test_mem_cycle_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  out_req = '0, in_req = '0, vp_enable = '0, vp_io_wait = '0;
  logic        instr_done = 1'b0, force_same = 1'b0;
  logic [16:0] grant;
  logic [2:0]  vp_id;

  int vectors = 0, fails = 0;
  int m_busy = 0, m_hold = 0, m_cur = 7;
  int e_slot, e_vp;
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_cycle_arbiter i_mem_cycle_arbiter (
    .clk(clk), .rst_n(rst_n), .out_req(out_req), .in_req(in_req),
    .vp_enable(vp_enable), .vp_io_wait(vp_io_wait),
    .instr_done(instr_done), .force_same(force_same),
    .grant(grant), .vp_id(vp_id));

  task automatic predict();
    e_slot = -1; e_vp = 0; e_tag = "R10";
    for (int i = 0; i < 8; i++)
      if (e_slot < 0 && out_req[i]) begin e_slot = i; e_tag = "R2"; end
    for (int i = 0; i < 8; i++)
      if (e_slot < 0 && in_req[i]) begin e_slot = 8 + i; e_tag = "R3"; end
    if (e_slot < 0) begin
      if (m_busy != 0) begin e_slot = 16; e_vp = m_cur; e_tag = "R5/R6"; end
      else if (m_hold != 0) begin e_slot = 16; e_vp = m_cur; e_tag = "R7"; end
      else begin
        for (int k = 1; k <= 8; k++) begin
          int c = (m_cur + k) % 8;
          if (e_slot < 0 && vp_enable[c] && !vp_io_wait[c]) begin
            e_slot = 16; e_vp = c; e_tag = "R4/R8/R9";
          end
        end
      end
    end
  endtask

  task automatic check_now(input string note);
    logic [16:0] eg;
    predict();
    eg = (e_slot < 0) ? 17'd0 : (17'd1 << e_slot);
    vectors++;
    if (grant !== eg || vp_id !== 3'(e_vp)) begin
      fails++;
      $display("FAIL %s %s: grant=%h vp_id=%0d expected grant=%h vp_id=%0d",
               e_tag, note, grant, vp_id, eg, e_vp);
    end
  endtask

  task automatic step(input string note);
    #1 check_now(note);
    @(posedge clk);
    if (rst_n && e_slot == 16) begin
      m_cur  = e_vp;
      m_busy = instr_done ? 0 : 1;
      m_hold = (instr_done && force_same) ? 1 : 0;
    end
    @(negedge clk);
  endtask

  task automatic rand_inputs(input int io_rate, input int done_rate);
    out_req    = ($urandom % io_rate == 0) ? 8'(1 << ($urandom % 8)) | 8'($urandom & $urandom) : 8'd0;
    in_req     = ($urandom % io_rate == 0) ? 8'($urandom) : 8'd0;
    vp_enable  = 8'($urandom | $urandom);
    vp_io_wait = 8'($urandom & $urandom & $urandom);
    instr_done = ($urandom % done_rate == 0);
    force_same = ($urandom % 5 == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R10: reset state, nothing requested
    for (int i = 0; i < 3; i++) step("reset");
    rst_n = 1'b1;
    step("idle after reset R10");

    // R4: first pick after reset is processor 0, then rotation
    vp_enable = 8'hFF; instr_done = 1'b1;
    for (int i = 0; i < 10; i++) step("rotation R4");

    // R5 R8: multi-cycle instruction, enables toggled mid-instruction
    instr_done = 1'b0;
    for (int i = 0; i < 4; i++) begin vp_enable = 8'($urandom); step("atomic R5 R8"); end
    instr_done = 1'b1; step("complete R5");

    // R6: I/O steals, then resumes same processor; R11 done ignored on I/O cycle
    vp_enable = 8'hFF; instr_done = 1'b0; step("start R6");
    out_req = 8'h04; instr_done = 1'b1; step("steal R6 R11");
    out_req = 8'h00; in_req = 8'h80; step("steal in R3 R11");
    in_req = 8'h00; instr_done = 1'b0; step("resume R6");
    instr_done = 1'b1; step("finish R6");

    // R7: forced repeat while processor gets disabled
    force_same = 1'b1; step("force R7");
    force_same = 1'b0; vp_enable = 8'h00; vp_io_wait = 8'hFF; step("forced repeat R7");
    step("no eligible R10");
    vp_io_wait = 8'h00;

    // R9: only stalled processors enabled
    vp_enable = 8'h0F; vp_io_wait = 8'h0F; step("stall R9");
    vp_io_wait = 8'h0B; step("one free R9");

    // R3: held input request from controller 0 keeps winning
    in_req = 8'h01;
    for (int i = 0; i < 4; i++) step("rescan R3");
    in_req = 8'h00;

    for (int i = 0; i < 2000; i++) begin rand_inputs(2, 3); step("random busy-io"); end
    for (int i = 0; i < 2000; i++) begin rand_inputs(6, 4); step("random sparse-io"); end
    for (int i = 0; i < 500; i++) begin rand_inputs(9, 1); step("random R1"); end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule